// File: doc/BRIEF.md
# Burst Bit-Error-Rate Monitor

This block estimates the channel bit error rate seen by a convolutional decoder on a burst-by-burst basis. Each decoded output bit is passed through a local copy of the rate-1/2, constraint-length-7 convolutional encoder. The two regenerated code bits are then compared with the hard decisions of the received I and Q symbols that produced that bit. A disagreement means the channel flipped that symbol, so the number of disagreements accumulated over a burst approximates the number of channel bit errors.

The caller supplies the decoded bit and its valid flag, the burst start and stop markers of the output stream, and the hard-decision and erase pair for each bit. The pair must already be delayed to line up with the decoded bit. A 16-bit measurement period sets how often the published count is refreshed while a burst is still running. The running total is also published when the burst ends. Counting is confined to cycles with valid output and restarts with every burst.

Top module: `burst_ber_monitor`

## Requirements
- R1: After the asynchronous active-low reset, `ber_count` reads 0, and the encoder history, running count and period count are all zero.
- R2: The re-encoder forms the 7-bit window {current bit, previous 6 bits}, with the current bit in the most significant position. Its first code bit c0 is the parity of the window masked with 171 octal, and its second code bit c1 is the parity of the window masked with 133 octal. On a burst start bit, the previous 6 bits are taken as zero, so a first bit of 1 encodes to c0=1, c1=1.
- R3: Each valid bit adds 0, 1 or 2 errors to the count. One error is added when c0 differs from `hard_i` and `erase_i` is low. One more is added when c1 differs from `hard_q` and `erase_q` is low. A hard bit of 1 means the sign bit of the received symbol indicated a one.
- R4: While `dec_valid` is low, every other input is ignored and no state changes. `ber_count` holds its value.
- R5: `ber_count` changes only on a cycle with `dec_valid` high that is either a period refresh (R6) or a stop bit (R7). It then takes the running count including that bit's errors, and the new value is visible after that clock edge.
- R6: A period refresh occurs when a valid bit brings the number of valid bits since the last refresh (or since the burst start) to `meas_period`. The period count then restarts from zero while the running count continues. A `meas_period` of 0 disables period refreshes.
- R7: A valid bit with `burst_stop` high publishes the running count including its own errors. It then clears the running count, the period count and the encoder history.
- R8: A valid bit with `burst_start` high clears the history, running count and period count before that bit is counted. The start bit itself is counted as the first bit of the new burst. Start and stop on the same bit form a one-bit burst.
- R9: The running count saturates at 16'hFFFF and never wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_bit | input | 1 | Decoded output bit |
| dec_valid | input | 1 | Decoded bit is valid this cycle |
| burst_start | input | 1 | First valid bit of an output burst |
| burst_stop | input | 1 | Last valid bit of an output burst |
| hard_i | input | 1 | Aligned hard decision of the I symbol |
| hard_q | input | 1 | Aligned hard decision of the Q symbol |
| erase_i | input | 1 | I symbol erased, excluded from comparison |
| erase_q | input | 1 | Q symbol erased, excluded from comparison |
| meas_period | input | 16 | Valid bits per refresh of the published count, 0 disables |
| ber_count | output | 16 | Published error count of the current burst |

## Verification
A corrupted bit of encoder history changes the regenerated code bits for the next six decoded bits. On a clean burst, this shows up as a nonzero `ber_count` at the next refresh or stop. A history that is not cleared at a start appears on the first bits of the following burst. A running or period counter that is off by one or fails to clear shows up at the first period boundary or stop marker as a count or refresh cycle that differs from the expected one. Because the bench compares `ber_count` after every clock edge, a refresh that arrives on the wrong cycle is reported on the cycle it occurs.

// File: rtl/bmon_pkg.sv
package bmon_pkg;

   localparam int ERR_W = 2;

   typedef enum logic [1:0] {
      PUB_NONE   = 2'd0,
      PUB_PERIOD = 2'd1,
      PUB_STOP   = 2'd2
   } pub_ev_t;

endpackage

// File: rtl/bmon_reencoder.sv
module bmon_reencoder #(
   parameter int          K  = 7,
   parameter logic [K-1:0] GA = 7'o171,
   parameter logic [K-1:0] GB = 7'o133
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         advance,
   input  logic         restart,
   input  logic         flush,
   input  logic         din,
   output logic         code_a,
   output logic         code_b,
   output logic [K-2:0] hist
);

   logic [K-2:0] hist_eff;
   logic [K-1:0] window;

   assign hist_eff = restart ? '0 : hist;
   assign window   = {din, hist_eff};
   assign code_a   = ^(window & GA);
   assign code_b   = ^(window & GB);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist <= '0;
      end else if (advance) begin
         if (flush) hist <= '0;
         else       hist <= window[K-1:1];
      end
   end

endmodule

// File: rtl/bmon_mismatch.sv
module bmon_mismatch #(
   parameter bit HONOR_ERASE = 1'b1
) (
   input  logic                      code_a,
   input  logic                      code_b,
   input  logic                      hard_i,
   input  logic                      hard_q,
   input  logic                      erase_i,
   input  logic                      erase_q,
   output logic [bmon_pkg::ERR_W-1:0] err
);

   logic miss_i, miss_q;

   generate
      if (HONOR_ERASE) begin : g_masked
         assign miss_i = (code_a ^ hard_i) & ~erase_i;
         assign miss_q = (code_b ^ hard_q) & ~erase_q;
      end else begin : g_plain
         logic unused_erase;
         assign unused_erase = erase_i ^ erase_q;
         assign miss_i = code_a ^ hard_i;
         assign miss_q = code_b ^ hard_q;
      end
   endgenerate

   assign err = {1'b0, miss_i} + {1'b0, miss_q};

endmodule

// File: rtl/bmon_sat_accum.sv
module bmon_sat_accum #(
   parameter int W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       advance,
   input  logic                       restart,
   input  logic                       flush,
   input  logic [bmon_pkg::ERR_W-1:0] inc,
   output logic [W-1:0]               run_next,
   output logic [W-1:0]               run
);

   logic [W-1:0] base;
   logic [W:0]   sum;

   assign base     = restart ? '0 : run;
   assign sum      = {1'b0, base} + {{(W+1-bmon_pkg::ERR_W){1'b0}}, inc};
   assign run_next = sum[W] ? {W{1'b1}} : sum[W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= '0;
      end else if (advance) begin
         if (flush) run <= '0;
         else       run <= run_next;
      end
   end

endmodule

// File: rtl/bmon_period.sv
module bmon_period #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         advance,
   input  logic         restart,
   input  logic         flush,
   input  logic [W-1:0] period,
   output logic         hit,
   output logic [W-1:0] cnt
);

   logic [W-1:0] cnt_next;

   assign cnt_next = (restart ? '0 : cnt) + {{(W-1){1'b0}}, 1'b1};
   assign hit      = (period != '0) && (cnt_next == period);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (advance) begin
         if (flush || hit) cnt <= '0;
         else              cnt <= cnt_next;
      end
   end

endmodule

// File: rtl/burst_ber_monitor.sv
module burst_ber_monitor #(
   parameter int           CNT_W       = 16,
   parameter int           K           = 7,
   parameter logic [K-1:0] POLY_A      = 7'o171,
   parameter logic [K-1:0] POLY_B      = 7'o133,
   parameter bit           HONOR_ERASE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dec_bit,
   input  logic             dec_valid,
   input  logic             burst_start,
   input  logic             burst_stop,
   input  logic             hard_i,
   input  logic             hard_q,
   input  logic             erase_i,
   input  logic             erase_q,
   input  logic [CNT_W-1:0] meas_period,
   output logic [CNT_W-1:0] ber_count
);

   import bmon_pkg::*;

   localparam int HIST_W = K - 1;

   generate
      if (K < 3 || K > 16) begin : g_bad_k
         initial $error("burst_ber_monitor: K out of range");
      end
      if (CNT_W < 4) begin : g_bad_w
         initial $error("burst_ber_monitor: CNT_W too small");
      end
      if (POLY_A[K-1] == 1'b0 || POLY_B[K-1] == 1'b0) begin : g_bad_poly
         initial $error("burst_ber_monitor: generator must tap current bit");
      end
   endgenerate

   logic              code_a, code_b;
   logic [HIST_W-1:0] enc_hist;
   logic [ERR_W-1:0]  err_cnt;
   logic [CNT_W-1:0]  run_next, run_cnt, per_cnt;
   logic              per_hit;
   pub_ev_t           pub_ev;

   bmon_reencoder #(.K(K), .GA(POLY_A), .GB(POLY_B)) u_enc (
      .clk(clk), .rst_n(rst_n), .advance(dec_valid), .restart(burst_start),
      .flush(burst_stop), .din(dec_bit), .code_a(code_a), .code_b(code_b),
      .hist(enc_hist)
   );

   bmon_mismatch #(.HONOR_ERASE(HONOR_ERASE)) u_cmp (
      .code_a(code_a), .code_b(code_b), .hard_i(hard_i), .hard_q(hard_q),
      .erase_i(erase_i), .erase_q(erase_q), .err(err_cnt)
   );

   bmon_sat_accum #(.W(CNT_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .advance(dec_valid), .restart(burst_start),
      .flush(burst_stop), .inc(err_cnt), .run_next(run_next), .run(run_cnt)
   );

   bmon_period #(.W(CNT_W)) u_per (
      .clk(clk), .rst_n(rst_n), .advance(dec_valid), .restart(burst_start),
      .flush(burst_stop), .period(meas_period), .hit(per_hit), .cnt(per_cnt)
   );

   always_comb begin
      pub_ev = PUB_NONE;
      if (dec_valid) begin
         if (burst_stop)   pub_ev = PUB_STOP;
         else if (per_hit) pub_ev = PUB_PERIOD;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                ber_count <= '0;
      else if (pub_ev != PUB_NONE) ber_count <= run_next;
   end

endmodule

// File: rtl/bmon_checker.sv
module bmon_checker #(
   parameter int W  = 16,
   parameter int HW = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          dec_valid,
   input logic          dec_bit,
   input logic          burst_start,
   input logic          burst_stop,
   input logic          erase_i,
   input logic          erase_q,
   input logic [W-1:0]  meas_period,
   input logic [W-1:0]  ber_count,
   input logic [W-1:0]  run_cnt,
   input logic [W-1:0]  per_cnt,
   input logic [HW-1:0] enc_hist,
   input logic [1:0]    err_cnt
);

   // R4: nothing published while output is not valid
   a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |=> $stable(ber_count));

   // R4: internal state frozen while output is not valid
   a_r4_state_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |=> ($stable(run_cnt) && $stable(per_cnt) && $stable(enc_hist)));

   // R3: at most two errors per bit, none when both components are erased
   a_r3_err_range: assert property (@(posedge clk) disable iff (!rst_n)
      err_cnt <= 2'd2);
   a_r3_erase_both: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_i && erase_q) |-> err_cnt == 2'd0);

   // R7: stop clears the burst state
   a_r7_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && burst_stop) |=> (run_cnt == '0 && per_cnt == '0 && enc_hist == '0));

   // R8: start bit enters an empty history
   a_r8_start_history: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && burst_start && !burst_stop) |=>
         enc_hist == {$past(dec_bit), {(HW-1){1'b0}}});

   // R8: start bit is the first counted bit of the period
   a_r8_start_period: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && burst_start && !burst_stop && meas_period != 1) |=> per_cnt == 1);

   // R9: running count never decreases inside a burst
   a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !burst_start && !burst_stop) |=> run_cnt >= $past(run_cnt));

endmodule

bind burst_ber_monitor bmon_checker #(.W(CNT_W), .HW(K-1)) u_chk (
   .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_bit(dec_bit),
   .burst_start(burst_start), .burst_stop(burst_stop), .erase_i(erase_i),
   .erase_q(erase_q), .meas_period(meas_period), .ber_count(ber_count),
   .run_cnt(run_cnt), .per_cnt(per_cnt), .enc_hist(enc_hist), .err_cnt(err_cnt)
);

// File: tb/burst_ber_monitor_test.sv
module burst_ber_monitor_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dec_bit = 0, dec_valid = 0, burst_start = 0, burst_stop = 0;
   logic        hard_i = 0, hard_q = 0, erase_i = 0, erase_q = 0;
   logic [15:0] meas_period = 16'd0;
   logic [15:0] ber_count;

   always #2 clk = ~clk;   // 250 MHz

   burst_ber_monitor uut (
      .clk(clk), .rst_n(rst_n), .dec_bit(dec_bit), .dec_valid(dec_valid),
      .burst_start(burst_start), .burst_stop(burst_stop), .hard_i(hard_i),
      .hard_q(hard_q), .erase_i(erase_i), .erase_q(erase_q),
      .meas_period(meas_period), .ber_count(ber_count)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference state, from the requirements
   logic [5:0]  m_hist = '0;
   logic [15:0] m_run = '0, m_per = '0, m_pub = '0;

   // returns {c1, c0} (R2)
   function automatic logic [1:0] enc(input logic b, input logic [5:0] h);
      logic [6:0] r;
      r = {b, h};
      return {^(r & 7'o133), ^(r & 7'o171)};
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model(input logic b, input logic st, input logic sp,
                        input logic hi, input logic hq, input logic ei, input logic eq);
      logic [5:0]  h;
      logic [1:0]  c;
      int          e;
      logic [16:0] s;
      logic [15:0] nr, np;
      h  = st ? 6'd0 : m_hist;
      c  = enc(b, h);
      e  = ((!ei && c[0] != hi) ? 1 : 0) + ((!eq && c[1] != hq) ? 1 : 0);
      s  = {1'b0, (st ? 16'd0 : m_run)} + 17'(e);
      nr = s[16] ? 16'hFFFF : s[15:0];
      np = (st ? 16'd0 : m_per) + 16'd1;
      if (sp) begin
         m_pub = nr; m_run = '0; m_per = '0; m_hist = '0;
      end else begin
         m_hist = {b, h[5:1]};
         m_run  = nr;
         if (meas_period != 0 && np == meas_period) begin
            m_pub = nr; m_per = '0;
         end else begin
            m_per = np;
         end
      end
   endtask

   task automatic cyc(input logic v, input logic b, input logic st, input logic sp,
                      input logic hi, input logic hq, input logic ei, input logic eq,
                      input string tag);
      dec_valid = v; dec_bit = b; burst_start = st; burst_stop = sp;
      hard_i = hi; hard_q = hq; erase_i = ei; erase_q = eq;
      @(posedge clk);
      if (v) model(b, st, sp, hi, hq, ei, eq);
      #1;
      check(tag, ber_count, m_pub);
   endtask

   // valid bit with correct symbols, optionally flipped
   task automatic send(input logic b, input logic st, input logic sp,
                       input logic fi, input logic fq, input logic ei, input logic eq,
                       input string tag);
      logic [1:0] c;
      c = enc(b, st ? 6'd0 : m_hist);
      cyc(1'b1, b, st, sp, c[0] ^ fi, c[1] ^ fq, ei, eq, tag);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         logic [7:0] r;
         r = 8'($urandom);
         cyc(1'b0, r[0], r[1], r[2], r[3], r[4], r[5], r[6], tag);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL R1 watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      #1;
      check("R1 reset value", ber_count, 16'd0);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      check("R1 after release", ber_count, 16'd0);

      // R2: first bit 1 after start encodes to (1,1)
      cyc(1, 1, 1, 1, 1, 1, 0, 0, "R2 start bit 1 clean");
      check("R2 explicit zero", ber_count, 16'd0);
      cyc(1, 1, 1, 1, 0, 0, 0, 0, "R2 start bit 1 both wrong");
      check("R2 explicit two", ber_count, 16'd2);

      // R8: stale history from a burst without stop is cleared by start
      send(1, 1, 0, 0, 0, 0, 0, "R8 prior burst");
      send(1, 0, 0, 0, 0, 0, 0, "R8 prior burst");
      send(0, 0, 0, 1, 0, 0, 0, "R8 prior burst");
      cyc(1, 1, 1, 1, 1, 1, 0, 0, "R8 start clears history");
      check("R8 explicit zero", ber_count, 16'd0);

      // R3/R7: clean burst, then single and double flips, erased flips
      for (int i = 0; i < 20; i++) send(1'($urandom), i == 0, i == 19, 0, 0, 0, 0, "R7 clean burst");
      check("R7 clean burst explicit", ber_count, 16'd0);
      for (int i = 0; i < 10; i++) send(1'($urandom), i == 0, i == 9, i == 4, 0, 0, 0, "R3 one flip");
      check("R3 one flip explicit", ber_count, 16'd1);
      for (int i = 0; i < 10; i++) send(1'($urandom), i == 0, i == 9, i == 2, i == 2, 0, 0, "R3 two flips");
      check("R3 two flips explicit", ber_count, 16'd2);
      for (int i = 0; i < 10; i++) send(1'($urandom), i == 0, i == 9, i == 3, i == 5, i == 3, i == 5, "R3 erased");
      check("R3 erased flips explicit", ber_count, 16'd0);

      // R4: garbage while not valid leaves the published value
      idle(12, "R4 idle garbage");
      check("R4 held explicit", ber_count, 16'd0);

      // R5/R6: period 4, one error per bit
      meas_period = 16'd4;
      for (int i = 0; i < 8; i++) begin
         send(1'($urandom), i == 0, 0, 1, 0, 0, 0, "R6 period");
         if (i < 3)      check("R5 before refresh", ber_count, 16'd0);
         else if (i < 7) check("R6 first refresh", ber_count, 16'd4);
         else            check("R6 second refresh", ber_count, 16'd8);
      end
      send(0, 0, 1, 1, 1, 0, 0, "R7 stop after periods");
      check("R7 stop total", ber_count, 16'd10);

      // R9: saturation
      meas_period = 16'd0;
      for (int i = 0; i < 32770; i++) send(1'($urandom), i == 0, 0, 1, 1, 0, 0, "R9 saturate");
      send(0, 0, 1, 1, 1, 0, 0, "R9 saturate stop");
      check("R9 saturated explicit", ber_count, 16'hFFFF);

      // random bursts
      for (int b = 0; b < 60; b++) begin
         int len;
         logic [1:0] pc;
         len = 1 + ($urandom % 150);
         pc  = 2'($urandom);
         meas_period = (pc == 0) ? 16'd0 : (pc == 1) ? 16'd1 : 16'(3 + $urandom % 40);
         for (int i = 0; i < len; i++) begin
            logic [7:0] r;
            r = 8'($urandom);
            send(r[0], i == 0, i == len - 1, r[3:1] == 0, r[6:4] == 0,
                 r[7] & r[1], r[7] & r[2], "R3 R6 R8 random");
            if (r[5:4] == 2'b11) idle(1 + ($urandom % 3), "R4 random gap");
         end
         idle($urandom % 5, "R4 between bursts");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule